// File: doc/BRIEF.md
# Shadow-Buffered PWM Generator

This block is one pulse-width generator that hangs off a single up-to-`CNT_W`-bit counter. It keeps a period (load) value and two compare thresholds. It drives two independent PWM outputs, A and B, from that one counter. It also reports when the counter sits at zero and when it equals the period value.

Software writes the period and both thresholds through a plain write port into shadow copies. A shadow reaches its active copy only on a clock edge where the running counter is at zero, so a period never changes halfway through. Each of the three shadows can instead be held back until a global synchronous-update strobe has been seen. This lets several generators switch to new settings on the same period boundary.

A debug-halt input freezes the counter the next time it reaches zero. A control bit makes the counter ignore that halt.

Top module: `pwm_deferred_gen`

## Requirements
- R1: After reset, `ctrl_rd`, `cnt_val`, `pwm_a`, `pwm_b`, `cnt_zero` and `cnt_at_load` are all 0. The active and shadow period and compare values are also 0.
- R2: A write with `wr_addr`=0 sets the control bits as follows: bit 0 enable, bit 1 up/down counting, bit 2 debug-run, bit 3 period deferred, bit 4 compare A deferred, bit 5 compare B deferred. Bits 31:6 of `ctrl_rd` always read 0 and ignore written data. Addresses 1, 2 and 3 write the period, compare A and compare B shadows from `wr_data[CNT_W-1:0]`.
- R3: While enable is 0, the counter is 0 on the next cycle, both PWM outputs are 0 on the next cycle, and no shadow is copied.
- R4: In down mode (bit 1 = 0), the counter takes the effective period value on the edge where it is 0. It then drops by one per cycle down to 0, and it never exceeds the active period.
- R5: In up/down mode (bit 1 = 1), the counter leaves 0 for 1 (or stays at 0 if the period is 0). It climbs by one until it equals the period, then falls by one back to 0, and repeats.
- R6: With a register's deferred bit at 0, a written value is copied to the active register on the next edge where the enabled counter is 0. A period copied on that edge is the value the counter reloads on the same edge.
- R7: With a register's deferred bit at 1, a written value stays in the shadow until `sync_req` has been sampled high in an earlier cycle while that write was pending. The value is then copied on the next edge where the enabled counter is 0, and both the pending write and the latched request are cleared.
- R8: A `sync_req` pulse sampled while a register has no pending write has no effect on that register. A later write still waits for a new pulse.
- R9: The three registers follow their own deferred bits independently. In the same period, one register can commit immediately while another keeps waiting.
- R10: With debug-run 0 and `dbg_halt` high, the counter stays at 0 once it reaches 0. It resumes in the cycle after `dbg_halt` falls. Commits at zero still occur while it is frozen.
- R11: With debug-run 1, `dbg_halt` has no effect on counting.
- R12: In down mode, each output is updated on every edge. It goes to 0 when the count equals its compare value. Otherwise it goes to 1 when the count equals the active period. Otherwise it holds.
- R13: In up/down mode, each output goes to 1 when the count equals its compare value while the direction is up, and to 0 on a match while the direction is down. The direction is down from the cycle after the count equals the period through the cycle the count returns to 0, and up otherwise (including the first cycle after enable).
- R14: `cnt_zero` is 1 exactly when enable is 1 and the count is 0. `cnt_at_load` is 1 exactly when enable is 1 and the count equals the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 control, 1 period, 2 compare A, 3 compare B |
| wr_data | input | DATA_W | Write data |
| dbg_halt | input | 1 | Debug halt request |
| sync_req | input | 1 | Global synchronous-update strobe |
| ctrl_rd | output | DATA_W | Control register read value |
| cnt_val | output | CNT_W | Current count |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| cnt_zero | output | 1 | Count is zero while enabled |
| cnt_at_load | output | 1 | Count equals active period while enabled |

## Verification
The bench sweeps small periods against every compare value from 0 to one past the period, in both counting modes. This catches outputs that get compare-versus-period priority wrong, or that handle a compare of 0 or an out-of-range compare incorrectly.

The deferred-update scenarios do three things:
- They leave a write waiting across several periods, then pulse `sync_req` before any write. A design that latched such a stray pulse would commit early.
- They mix deferred and immediate bits across the three registers. A design that shares one policy would commit the wrong register.
- They change the period while running. A design that reloaded the old period on the commit edge would stretch one period.

Debug halt is raised mid-count, with and without debug-run set. A counter that stops away from zero, or never stops, shows up at once on `cnt_val`.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam int CTRL_W      = 6;
  localparam int NUM_SHADOW  = 3;
  localparam int DEFER_BASE  = 3;

  typedef struct packed {
    logic cmpb_defer;
    logic cmpa_defer;
    logic load_defer;
    logic dbg_run;
    logic updown;
    logic enable;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CMPA = 2'd2,
    SEL_CMPB = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         defer,
  input  logic         sync_req,
  input  logic         zero_evt,
  output logic [W-1:0] active_q,
  output logic [W-1:0] active_nxt
);

  logic [W-1:0] shadow_q;
  logic         pend_q;
  logic         sync_q;
  logic         commit;

  // a pending value may move only at a zero edge, and in deferred mode only after a latched request
  function automatic logic may_commit(input logic zev, input logic pend,
                                      input logic dfr, input logic syn);
    return zev && pend && (!dfr || syn);
  endfunction

  assign commit     = may_commit(zero_evt, pend_q, defer, sync_q);
  assign active_nxt = commit ? shadow_q : active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      active_q <= active_nxt;
      if (wr_en) shadow_q <= wr_data;
      if (wr_en)       pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;
      if (commit)                 sync_q <= 1'b0;
      else if (sync_req && pend_q) sync_q <= 1'b1;
    end
  end

  AST_HOLD_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_evt |=> $stable(active_q)); // R6

  AST_DEFER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt && defer && !sync_q |=> $stable(active_q)); // R7

  AST_NO_STRAY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && !sync_q |=> !sync_q); // R8

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         updown,
  input  logic         freeze_req,
  input  logic [W-1:0] load_nxt,
  output logic [W-1:0] cnt_q,
  output logic         dir_q,
  output logic         zero_evt
);

  localparam logic [W-1:0] ONE = W'(1);

  logic         freeze;
  logic [W:0]   step;

  // returns {dir, count} for the next cycle while running
  function automatic logic [W:0] count_step(input logic [W-1:0] c, input logic d,
                                            input logic [W-1:0] ld, input logic ud);
    logic [W:0] r;
    if (!ud) begin
      r = (c == '0) ? {1'b1, ld} : {1'b1, c - ONE};
    end else if (c == '0) begin
      r = {1'b1, (ld == '0) ? '0 : ONE};
    end else if (d && (c >= ld)) begin
      r = {1'b0, c - ONE};
    end else if (d) begin
      r = {1'b1, c + ONE};
    end else begin
      r = {1'b0, c - ONE};
    end
    return r;
  endfunction

  assign zero_evt = en && (cnt_q == '0);
  assign freeze   = zero_evt && freeze_req;
  assign step     = count_step(cnt_q, dir_q, load_nxt, updown);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (!en) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (!freeze) begin
      cnt_q <= step[W-1:0];
      dir_q <= step[W];
    end
  end

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0); // R3

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt && freeze_req |=> cnt_q == '0); // R10

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && !updown && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE); // R4

  AST_UP_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt && updown && !freeze_req && (load_nxt != '0) |=> cnt_q == ONE); // R5

endmodule

// File: rtl/pwm_out_drv.sv
module pwm_out_drv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         updown,
  input  logic [W-1:0] cnt,
  input  logic         dir_up,
  input  logic [W-1:0] load,
  input  logic [W-1:0] cmp,
  output logic         pwm_q
);

  logic pwm_nxt;

  function automatic logic edge_level(input logic cur, input logic ud, input logic up,
                                      input logic hit_cmp, input logic hit_load);
    logic r;
    r = cur;
    if (ud) begin
      if (hit_cmp) r = up;
    end else if (hit_cmp) begin
      r = 1'b0;
    end else if (hit_load) begin
      r = 1'b1;
    end
    return r;
  endfunction

  assign pwm_nxt = en ? edge_level(pwm_q, updown, dir_up, cnt == cmp, cnt == load) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_nxt;
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q); // R3

  AST_DOWN_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en && !updown && (cnt == cmp) |=> !pwm_q); // R12

  AST_UD_CMP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    en && updown && dir_up && (cnt == cmp) |=> pwm_q); // R13

endmodule

// File: rtl/pwm_deferred_gen.sv
module pwm_deferred_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_halt,
  input  logic              sync_req,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              cnt_zero,
  output logic              cnt_at_load
);

  localparam int NUM_OUT = 2;

  ctrl_t                                 ctrl_q;
  logic [CTRL_W-1:0]                     ctrl_bits;
  logic                                  ctrl_wr;
  logic [NUM_SHADOW-1:0][CNT_W-1:0]      act_q;
  logic [NUM_SHADOW-1:0][CNT_W-1:0]      act_nxt;
  logic [CNT_W-1:0]                      cnt_q;
  logic                                  dir_q;
  logic                                  zero_evt;
  logic                                  freeze_req;
  logic [NUM_OUT-1:0]                    pwm_q;
  logic                                  unused_wr_hi;
  logic                                  unused_cmp_nxt;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(SEL_CTRL));
  assign ctrl_bits = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  assign ctrl_rd = {{(DATA_W-CTRL_W){1'b0}}, ctrl_bits};

  for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_shadow
    pwm_shadow_reg #(.W(CNT_W)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en && (wr_addr == ADDR_W'(i + 1))),
      .wr_data    (wr_data[CNT_W-1:0]),
      .defer      (ctrl_bits[DEFER_BASE + i]),
      .sync_req   (sync_req),
      .zero_evt   (zero_evt),
      .active_q   (act_q[i]),
      .active_nxt (act_nxt[i])
    );
  end

  assign freeze_req = dbg_halt && !ctrl_q.dbg_run;

  pwm_counter #(.W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctrl_q.enable),
    .updown     (ctrl_q.updown),
    .freeze_req (freeze_req),
    .load_nxt   (act_nxt[0]),
    .cnt_q      (cnt_q),
    .dir_q      (dir_q),
    .zero_evt   (zero_evt)
  );

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    pwm_out_drv #(.W(CNT_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl_q.enable),
      .updown (ctrl_q.updown),
      .cnt    (cnt_q),
      .dir_up (dir_q),
      .load   (act_q[0]),
      .cmp    (act_q[j + 1]),
      .pwm_q  (pwm_q[j])
    );
  end

  assign pwm_a          = pwm_q[0];
  assign pwm_b          = pwm_q[1];
  assign cnt_val        = cnt_q;
  assign cnt_zero       = zero_evt;
  assign cnt_at_load    = ctrl_q.enable && (cnt_q == act_q[0]);
  assign unused_wr_hi   = ^wr_data[DATA_W-1:CNT_W];
  assign unused_cmp_nxt = ^{act_nxt[1], act_nxt[2]};

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q[0]); // R4

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero && (act_q[0] != '0) |-> !cnt_at_load); // R14

endmodule

// File: tb/pwm_deferred_gen_test.sv
`timescale 1ns/1ps
module pwm_deferred_gen_test;

  localparam int MAX_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        dbg_halt = 1'b0;
  logic        sync_req = 1'b0;
  logic [31:0] ctrl_rd;
  logic [15:0] cnt_val;
  logic        pwm_a, pwm_b, cnt_zero, cnt_at_load;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;
  string       cur_req = "R1";

  // reference state
  logic [5:0]  mc = '0;
  logic [15:0] mcnt = '0;
  logic        mdir = 1'b1;
  logic [15:0] msh [3] = '{default: '0};
  logic [15:0] mact [3] = '{default: '0};
  logic        mpend [3] = '{default: 1'b0};
  logic        msync [3] = '{default: 1'b0};
  logic        mp [2] = '{default: 1'b0};

  always #2.5 clk = ~clk;

  pwm_deferred_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_halt(dbg_halt), .sync_req(sync_req), .ctrl_rd(ctrl_rd), .cnt_val(cnt_val),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt_zero(cnt_zero), .cnt_at_load(cnt_at_load)
  );

  // reference model stepped on each edge from the requirement text
  always @(posedge clk) begin : model
    logic        z;
    logic        com [3];
    logic [15:0] nact [3];
    logic [15:0] ncnt;
    logic        ndir;
    logic        np [2];
    logic [15:0] c;
    if (!rst_n) begin
      mc = '0; mcnt = '0; mdir = 1'b1;
      for (int i = 0; i < 3; i++) begin
        msh[i] = '0; mact[i] = '0; mpend[i] = 1'b0; msync[i] = 1'b0;
      end
      mp[0] = 1'b0; mp[1] = 1'b0;
    end else begin
      z = mc[0] && (mcnt == 16'd0);
      for (int i = 0; i < 3; i++) begin
        com[i]  = z && mpend[i] && (!mc[3+i] || msync[i]);
        nact[i] = com[i] ? msh[i] : mact[i];
      end
      for (int j = 0; j < 2; j++) begin
        c = mact[j+1];
        if (!mc[0])            np[j] = 1'b0;
        else if (mc[1])        np[j] = (mcnt == c) ? mdir : mp[j];
        else if (mcnt == c)    np[j] = 1'b0;
        else if (mcnt == mact[0]) np[j] = 1'b1;
        else                   np[j] = mp[j];
      end
      ncnt = mcnt; ndir = mdir;
      if (!mc[0]) begin
        ncnt = 0; ndir = 1'b1;
      end else if (z && dbg_halt && !mc[2]) begin
        ncnt = mcnt;
      end else if (!mc[1]) begin
        ndir = 1'b1;
        ncnt = z ? nact[0] : mcnt - 16'd1;
      end else if (z) begin
        ndir = 1'b1;
        ncnt = (nact[0] == 0) ? 16'd0 : 16'd1;
      end else if (mdir && mcnt >= nact[0]) begin
        ndir = 1'b0; ncnt = mcnt - 16'd1;
      end else if (mdir) begin
        ncnt = mcnt + 16'd1;
      end else begin
        ncnt = mcnt - 16'd1;
      end
      for (int i = 0; i < 3; i++) begin
        if (com[i]) msync[i] = 1'b0;
        else if (sync_req && mpend[i]) msync[i] = 1'b1;
        if (wr_en && wr_addr == 2'(i + 1)) begin
          msh[i] = wr_data[15:0]; mpend[i] = 1'b1;
        end else if (com[i]) begin
          mpend[i] = 1'b0;
        end
        mact[i] = nact[i];
      end
      if (wr_en && wr_addr == 2'd0) mc = wr_data[5:0];
      mcnt = ncnt; mdir = ndir; mp[0] = np[0]; mp[1] = np[1];
    end
  end

  task automatic chk(input string sig, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, sig, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("ctrl_rd", ctrl_rd, {26'd0, mc});
      chk("cnt_val", {16'd0, cnt_val}, {16'd0, mcnt});
      chk("pwm_a", {31'd0, pwm_a}, {31'd0, mp[0]});
      chk("pwm_b", {31'd0, pwm_b}, {31'd0, mp[1]});
      chk("cnt_zero", {31'd0, cnt_zero}, {31'd0, mc[0] && mcnt == 0});
      chk("cnt_at_load", {31'd0, cnt_at_load}, {31'd0, mc[0] && mcnt == mact[0]});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  task automatic pulse_sync();
    @(posedge clk); #1; sync_req = 1'b1;
    @(posedge clk); #1; sync_req = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    run(4);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    run(4);

    // reserved bits and field positions
    cur_req = "R2";
    wr(2'd0, 32'hFFFF_FFC0); run(2);
    wr(2'd0, 32'h0000_003E); run(2);
    wr(2'd0, 32'h0000_0000); run(2);

    // disabled: shadows must not reach the counter
    cur_req = "R3";
    wr(2'd1, 32'd5); wr(2'd2, 32'd2); run(10);

    // sweep periods and compares, down mode
    cur_req = "R4 R12 R14";
    for (int l = 0; l < 6; l++) begin
      for (int a = 0; a <= l + 1; a++) begin
        wr(2'd0, 32'd0);
        wr(2'd1, 32'(l)); wr(2'd2, 32'(a)); wr(2'd3, 32'(l + 1 - a));
        wr(2'd0, 32'h1); run(2 * l + 6);
      end
    end

    // sweep, up/down mode
    cur_req = "R5 R13 R14";
    for (int l = 0; l < 6; l++) begin
      for (int a = 0; a <= l + 1; a++) begin
        wr(2'd0, 32'd0);
        wr(2'd1, 32'(l)); wr(2'd2, 32'(a)); wr(2'd3, 32'(l + 1 - a));
        wr(2'd0, 32'h3); run(4 * l + 6);
      end
    end

    // immediate updates while running
    cur_req = "R6";
    wr(2'd0, 32'd0); wr(2'd1, 32'd7); wr(2'd2, 32'd3); wr(2'd0, 32'h1);
    run(5); wr(2'd1, 32'd3); wr(2'd3, 32'd1); run(20);

    // deferred period: waits for the strobe
    cur_req = "R7";
    wr(2'd0, 32'h9); wr(2'd1, 32'd4); run(25);
    pulse_sync(); run(20);

    // strobe with nothing pending is dropped
    cur_req = "R8";
    pulse_sync(); run(3);
    wr(2'd1, 32'd6); run(25);
    pulse_sync(); run(20);

    // mixed policies
    cur_req = "R9";
    wr(2'd0, 32'h29); wr(2'd1, 32'd5); wr(2'd2, 32'd1); wr(2'd3, 32'd2); run(20);
    pulse_sync(); run(20);

    // debug halt freezes at zero
    cur_req = "R10";
    wr(2'd0, 32'h1); wr(2'd1, 32'd6); run(4);
    @(posedge clk); #1 dbg_halt = 1'b1;
    wr(2'd2, 32'd4); run(20);
    @(posedge clk); #1 dbg_halt = 1'b0; run(15);

    // debug-run ignores halt
    cur_req = "R11";
    wr(2'd0, 32'h7); @(posedge clk); #1 dbg_halt = 1'b1; run(30);
    @(posedge clk); #1 dbg_halt = 1'b0; run(5);

    cur_req = "R3";
    wr(2'd0, 32'd0); run(5);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(MAX_CYC * 5);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL %s watchdog: got hung run expected completion", cur_req);
      summary();
      $finish;
    end
  end

endmodule